// File: doc/BRIEF.md
# Presettable Dual-Clock Up/Down Counter

A four-bit counter with two independent count clocks. A rising edge on the up clock advances the count and a rising edge on the down clock steps it back. A build-time parameter picks decade operation (0 to 9) or full binary operation (0 to 15). An active-high clear and an active-low load both override counting. While the load input is low, the count outputs follow the four preset inputs.

Two active-low terminal-count outputs follow the level of their count clock: carry and borrow. Carry can drive the up clock of a following stage and borrow can drive its down clock, so wider counters are built with no glue logic. Both count clocks are treated as asynchronous signals. They pass through a synchronizer on the system clock and go to a rising-edge detector, so all state changes happen on that one clock.

Top module: `dcc_top`

## Requirements
- R1: A rising edge on `upClk` increments the count and one on `downClk` decrements it. The new value appears at `q` on the third rising `clk` edge after the new clock level is first sampled.
- R2: With `DECADE=1` the count wraps from 9 to 0 going up and from 0 to 9 going down. With `DECADE=0` it wraps from 15 to 0 going up and from 0 to 15 going down.
- R3: While `masterClear` is high, `q` reads 0 at once. This holds whatever `loadN`, `upClk` and `downClk` are doing, and the count stays 0 after `masterClear` falls.
- R4: While `loadN` is low and `masterClear` is low, `q` equals `preset` with no `clk` edge needed. Count edges are ignored, and the preset value is kept after `loadN` rises.
- R5: `carryN` is low only while `upClk` is low and the count is at its top. In decade mode the top is bit 0 and bit 3 both set. In binary mode the top is all four bits set. Otherwise `carryN` is high.
- R6: `borrowN` is low only while `downClk` is low and the count is 0. Otherwise it is high.
- R7: When two stages are chained (carryN to the next up clock, borrowN to the next down clock), the pair counts as one two-digit counter in both directions.
- R8: In decade mode, a loaded count of 10 to 15 goes to 0 on the next up count and to 9 on the next down count.
- R9: If rising edges of both count clocks are detected in the same `clk` cycle, the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count clocks and updates the state |
| masterClear | input | 1 | Active-high asynchronous clear |
| loadN | input | 1 | Active-low asynchronous preset load |
| preset | input | 4 | Value taken while loading |
| upClk | input | 1 | Count-up clock, active on its rising edge |
| downClk | input | 1 | Count-down clock, active on its rising edge |
| q | output | 4 | Current count |
| carryN | output | 1 | Active-low terminal count going up |
| borrowN | output | 1 | Active-low terminal count going down |

## Verification
The same sequence of loads and count pulses goes to a decade instance and a binary instance in parallel. At counts of 9 and 15 their results diverge, which separates the two wrap rules. Loaded values of 10 to 15 followed by single up or down pulses show where the decade counter recovers. Directed cases hold load or clear against count pulses, raise both clocks together, and park each clock low at a terminal count to check carry and borrow. A two-stage chain counted across a digit in both directions checks that the terminal-count outputs drive the next stage correctly.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int CNT_W = 4;
  typedef logic [CNT_W-1:0] count_t;
  typedef struct packed {
    logic load;
    logic inc;
    logic dec;
  } strobe_t;
endpackage

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
  import dcc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    masterClear,
  input  logic    loadN,
  input  logic    upClk,
  input  logic    downClk,
  output strobe_t stb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] upSync, downSync;
  logic upPrev, downPrev;
  logic upEdge, downEdge;

  // idle level of both count clocks is high, so flops clear to 1
  always_ff @(posedge clk or posedge masterClear) begin
    if (masterClear) begin
      upSync   <= '1;
      downSync <= '1;
      upPrev   <= 1'b1;
      downPrev <= 1'b1;
    end else begin
      upSync   <= {upSync[LAST-1:0], upClk};
      downSync <= {downSync[LAST-1:0], downClk};
      upPrev   <= upSync[LAST];
      downPrev <= downSync[LAST];
    end
  end

  assign upEdge   = upSync[LAST] & ~upPrev;
  assign downEdge = downSync[LAST] & ~downPrev;

  always_comb begin
    stb.load = ~loadN;
    stb.inc  = upEdge & ~downEdge & loadN;
    stb.dec  = downEdge & ~upEdge & loadN;
  end
endmodule

// File: rtl/dcc_datapath.sv
module dcc_datapath
  import dcc_pkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input  logic    clk,
  input  logic    masterClear,
  input  logic    loadN,
  input  count_t  preset,
  input  logic    upClk,
  input  logic    downClk,
  input  strobe_t stb,
  output count_t  q,
  output logic    carryN,
  output logic    borrowN
);
  localparam count_t TOP = DECADE ? count_t'(9) : count_t'(15);

  count_t state, nextUp, nextDown;
  logic atTop;

  always_comb begin
    nextUp = (state >= TOP) ? '0 : state + 1'b1;
    if (state == '0)      nextDown = TOP;
    else if (state > TOP) nextDown = TOP;
    else                  nextDown = state - 1'b1;
  end

  always_ff @(posedge clk or posedge masterClear) begin
    if (masterClear)   state <= '0;
    else if (stb.load) state <= preset;
    else if (stb.inc)  state <= nextUp;
    else if (stb.dec)  state <= nextDown;
  end

  // clear and load reach the outputs without waiting for clk
  assign q = masterClear ? '0 : (!loadN ? preset : state);

  if (DECADE) begin : g_decade
    assign atTop = q[0] & q[CNT_W-1];
  end else begin : g_binary
    assign atTop = &q;
  end

  assign carryN  = ~(atTop & ~upClk);
  assign borrowN = ~((q == '0) & ~downClk);
endmodule

// File: rtl/dcc_top.sv
module dcc_top
  import dcc_pkg::*;
#(
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       masterClear,
  input  logic       loadN,
  input  logic [3:0] preset,
  input  logic       upClk,
  input  logic       downClk,
  output logic [3:0] q,
  output logic       carryN,
  output logic       borrowN
);
  strobe_t ctrlStb;

  dcc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .masterClear(masterClear), .loadN(loadN),
    .upClk(upClk), .downClk(downClk), .stb(ctrlStb)
  );

  dcc_datapath #(.DECADE(DECADE)) u_datapath (
    .clk(clk), .masterClear(masterClear), .loadN(loadN), .preset(preset),
    .upClk(upClk), .downClk(downClk), .stb(ctrlStb),
    .q(q), .carryN(carryN), .borrowN(borrowN)
  );
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker
  import dcc_pkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input logic    clk,
  input logic    masterClear,
  input logic    loadN,
  input count_t  preset,
  input logic    upClk,
  input logic    downClk,
  input count_t  q,
  input logic    carryN,
  input logic    borrowN,
  input strobe_t stb
);
  localparam count_t TOP = DECADE ? count_t'(9) : count_t'(15);

  always @(negedge clk) begin
    if (masterClear) AST_CLEAR_ZERO: assert (q == '0); // R3
    if (!masterClear && !loadN) AST_LOAD_FOLLOW: assert (q == preset); // R4
    if (!carryN) AST_CARRY_TERMINAL: assert (!upClk && q[0] && q[3]); // R5
    if (!borrowN) AST_BORROW_ZERO: assert (!downClk && q == '0); // R6
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (masterClear)
    (loadN && !stb.inc && !stb.dec) |=> (!loadN || $stable(q))); // R9
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (masterClear)
    (stb.inc && q == TOP) |=> (!loadN || q == '0)); // R2
  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (masterClear)
    (stb.dec && q == '0) |=> (!loadN || q == TOP)); // R2
  AST_DECADE_RANGE: assert property (@(posedge clk) disable iff (masterClear)
    (DECADE && loadN && $past(loadN) && $past(q) <= TOP) |-> (q <= TOP)); // R8
endmodule

bind dcc_top dcc_checker #(.DECADE(DECADE)) u_dccChecker (
  .clk(clk), .masterClear(masterClear), .loadN(loadN), .preset(preset),
  .upClk(upClk), .downClk(downClk), .q(q), .carryN(carryN),
  .borrowN(borrowN), .stb(ctrlStb)
);

// File: tb/test_dcc_top.sv
module test_dcc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;
  // {op(0 up,1 down,2 load), data, expected decade, expected binary}
  localparam logic [13:0] VEC [NVEC] = '{
    {2'd2, 4'd8,  4'd8,  4'd8},  {2'd0, 4'd0, 4'd9,  4'd9},
    {2'd0, 4'd0,  4'd0,  4'd10}, {2'd0, 4'd0, 4'd1,  4'd11},
    {2'd1, 4'd0,  4'd0,  4'd10}, {2'd1, 4'd0, 4'd9,  4'd9},
    {2'd2, 4'd0,  4'd0,  4'd0},  {2'd1, 4'd0, 4'd9,  4'd15},
    {2'd0, 4'd0,  4'd0,  4'd0},  {2'd2, 4'd15, 4'd15, 4'd15},
    {2'd0, 4'd0,  4'd0,  4'd0},  {2'd2, 4'd10, 4'd10, 4'd10},
    {2'd1, 4'd0,  4'd9,  4'd9},  {2'd2, 4'd14, 4'd14, 4'd14},
    {2'd1, 4'd0,  4'd9,  4'd13}, {2'd2, 4'd12, 4'd12, 4'd12},
    {2'd0, 4'd0,  4'd0,  4'd13}
  };

  logic clk = 1'b0;
  logic masterClear = 1'b1, loadN = 1'b1, upClk = 1'b1, downClk = 1'b1;
  logic casUp = 1'b1, casDown = 1'b1, casLoadN = 1'b1;
  logic [3:0] preset = 4'd0;
  logic [3:0] qDec, qBin, qLo, qHi;
  logic carryDec, borrowDec, carryBin, borrowBin;
  logic carryLo, borrowLo, carryHi, borrowHi;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcc_top #(.DECADE(1'b1)) i_dcc_top (
    .clk(clk), .masterClear(masterClear), .loadN(loadN), .preset(preset),
    .upClk(upClk), .downClk(downClk), .q(qDec), .carryN(carryDec), .borrowN(borrowDec));
  dcc_top #(.DECADE(1'b0)) i_dcc_bin (
    .clk(clk), .masterClear(masterClear), .loadN(loadN), .preset(preset),
    .upClk(upClk), .downClk(downClk), .q(qBin), .carryN(carryBin), .borrowN(borrowBin));
  dcc_top #(.DECADE(1'b1)) i_stageLo (
    .clk(clk), .masterClear(masterClear), .loadN(casLoadN), .preset(4'd0),
    .upClk(casUp), .downClk(casDown), .q(qLo), .carryN(carryLo), .borrowN(borrowLo));
  dcc_top #(.DECADE(1'b1)) i_stageHi (
    .clk(clk), .masterClear(masterClear), .loadN(casLoadN), .preset(4'd0),
    .upClk(carryLo), .downClk(borrowLo), .q(qHi), .carryN(carryHi), .borrowN(borrowHi));

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic setClk(input int which, input logic v);
    case (which)
      0: upClk = v;
      1: downClk = v;
      2: casUp = v;
      default: casDown = v;
    endcase
  endtask

  // low for two cycles, then high; result settled five cycles later
  task automatic pulse(input int which);
    @(negedge clk); setClk(which, 1'b0);
    repeat (2) @(negedge clk);
    setClk(which, 1'b1);
    repeat (5) @(negedge clk);
  endtask

  task automatic doLoad(input logic [3:0] v);
    @(negedge clk); preset = v; loadN = 1'b0;
    repeat (2) @(negedge clk);
    loadN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    bit invalid;
    // reset state
    repeat (3) @(negedge clk);
    check("R3 reset q", qDec, 4'd0);
    check("R3 reset carry/borrow", {2'b00, carryDec, borrowDec}, 4'b0011);
    @(negedge clk); masterClear = 1'b0;
    repeat (2) @(negedge clk);

    // vector table through both modes
    invalid = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][13:12])
        2'd0: pulse(0);
        2'd1: pulse(1);
        default: doLoad(VEC[i][11:8]);
      endcase
      check(invalid ? "R8 decade vector" : "R2 decade vector", qDec, VEC[i][7:4]);
      check("R1 binary vector", qBin, VEC[i][3:0]);
      invalid = (VEC[i][13:12] == 2'd2) && (VEC[i][11:8] > 4'd9);
    end

    // asynchronous load, count edges ignored while loading
    @(negedge clk); #1 preset = 4'd7; loadN = 1'b0;
    #1 check("R4 load without clock edge", qDec, 4'd7);
    pulse(0);
    check("R4 up ignored during load", qDec, 4'd7);
    pulse(1);
    check("R4 down ignored during load", qBin, 4'd7);
    loadN = 1'b1; preset = 4'd2;
    repeat (2) @(negedge clk);
    check("R4 value kept after release", qDec, 4'd7);

    // clear overrides load and counting
    @(negedge clk); preset = 4'd5; loadN = 1'b0;
    #1 masterClear = 1'b1;
    #1 check("R3 clear over load", qDec, 4'd0);
    setClk(0, 1'b0); repeat (2) @(negedge clk); setClk(0, 1'b1);
    repeat (5) @(negedge clk);
    check("R3 clear over count", qBin, 4'd0);
    loadN = 1'b1;
    @(negedge clk); masterClear = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 zero after clear release", qDec, 4'd0);

    // both clocks rise together
    doLoad(4'd4);
    @(negedge clk); upClk = 1'b0; downClk = 1'b0;
    repeat (2) @(negedge clk);
    upClk = 1'b1; downClk = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 simultaneous edges decade", qDec, 4'd4);
    check("R9 simultaneous edges binary", qBin, 4'd4);

    // carry at 9: decade low, binary high
    doLoad(4'd9);
    @(negedge clk); upClk = 1'b0; #1;
    check("R5 decade carry at 9", {3'b0, carryDec}, 4'd0);
    check("R5 binary carry at 9", {3'b0, carryBin}, 4'd1);
    @(negedge clk); upClk = 1'b1; #1;
    check("R5 carry high with clock high", {3'b0, carryDec}, 4'd1);
    repeat (5) @(negedge clk);
    check("R1 count on clock release", qBin, 4'd10);
    doLoad(4'd15);
    @(negedge clk); upClk = 1'b0; #1;
    check("R5 binary carry at 15", {3'b0, carryBin}, 4'd0);
    @(negedge clk); upClk = 1'b1;
    repeat (5) @(negedge clk);
    doLoad(4'd0);
    @(negedge clk); downClk = 1'b0; #1;
    check("R6 borrow at zero", {2'b0, borrowDec, borrowBin}, 4'd0);
    @(negedge clk); downClk = 1'b1; #1;
    check("R6 borrow high with clock high", {3'b0, borrowDec}, 4'd1);
    repeat (5) @(negedge clk);
    check("R2 decade down wrap", qDec, 4'd9);
    doLoad(4'd3);
    @(negedge clk); downClk = 1'b0; #1;
    check("R6 borrow high when nonzero", {3'b0, borrowDec}, 4'd1);
    @(negedge clk); downClk = 1'b1;
    repeat (5) @(negedge clk);

    // two-stage cascade
    for (int i = 0; i < 12; i++) pulse(2);
    check("R7 cascade up low digit", qLo, 4'd2);
    check("R7 cascade up high digit", qHi, 4'd1);
    for (int i = 0; i < 3; i++) pulse(3);
    check("R7 cascade down low digit", qLo, 4'd9);
    check("R7 cascade down high digit", qHi, 4'd0);

    finishRun();
  end
endmodule